// File: doc/BRIEF.md
# Line-Activity Interval Timer and Cycle Counter

This block watches a single data line and measures its activity in two ways. The first is a 40-bit interval timer. It advances once per 256 Hz tick while it runs, so its lowest byte holds fractions of a second. The second is a 32-bit cycle counter. It counts high-to-low transitions of the line, but only a transition that follows a high level held long enough to qualify. Both values are presented continuously to whatever captures them for the host.

The timer has two operating modes. In manual mode a run bit alone decides whether it advances. In automatic mode it starts once the line has stayed high for a qualification period, and it stops once the line has stayed low for a qualification period. A delay-select bit chooses the length of that period. It is measured in oscillator ticks taken after a two-stage synchroniser on the line. An oscillator-enable bit freezes all counting and qualification while it is clear.

Top module: `lat_activity_timer`

## Requirements
- R1: While `rstN` is low, both `intervalCount` and `cycleCount` are zero, and they stay zero on the first cycle after release.
- R2: `intervalCount` rises by exactly one in each clock cycle in which `tick256` is high, `oscEnable` is high and the timer is running. It never changes in a cycle without `tick256`.
- R3: With `autoMode` = 0 the timer runs exactly when `runManual` = 1. Activity on `lineIn` has no effect on it.
- R4: With `autoMode` = 1 the timer starts running once the synchronised line has been high for a full qualification period. The period is 128 counted oscillator ticks when `delaySel` = 0.
- R5: With `autoMode` = 1 the timer stops running once the synchronised line has been low for a full qualification period.
- R6: With `delaySel` = 1 the qualification period is 4096 counted oscillator ticks.
- R7: Each level change on the synchronised line restarts qualification from zero. A line change reaches the qualifier two clocks after `lineIn`.
- R8: `cycleCount` rises by one on a high-to-low change of the synchronised line only if the high level had already qualified. A fall after an unqualified high leaves it unchanged.
- R9: While `oscEnable` = 0, neither counter changes and qualification does not progress. Oscillator ticks count only when both `oscTick` and `oscEnable` are high.
- R10: Both counters wrap silently from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Monitored data line, asynchronous |
| oscTick | input | 1 | One-cycle oscillator tick enable (qualification time base) |
| tick256 | input | 1 | One-cycle 256 Hz enable for the interval timer |
| oscEnable | input | 1 | Oscillator running; 0 freezes everything |
| autoMode | input | 1 | 1 = line-controlled timer, 0 = manual |
| runManual | input | 1 | Manual-mode run bit |
| delaySel | input | 1 | 0 = 128-tick qualification, 1 = 4096-tick qualification |
| intervalCount | output | 40 | Interval timer value (low byte = 1/256 s) |
| cycleCount | output | 32 | Qualified falling-edge count |

## Verification
The hardest situations to reach from the ports are counter wrap-around and the long 4096-tick qualification window. The wrap of a 40-bit or 32-bit count cannot be reached by stimulus in a bounded run. The bench therefore runs a second instance with one-byte counters on the same stimulus, and drives more than 256 timer ticks and more than 256 qualified line cycles through it. Qualification edges are approached with highs and lows a few ticks either side of the period, with glitches inserted partway through, and with the oscillator stopped mid-window. A behavioural model confirms the exact cycle at which the timer starts or stops.

// File: rtl/lat_pkg.sv
package lat_pkg;

  // Per-cycle advance requests from control to datapath
  typedef struct packed {
    logic timerStep;
    logic cycleStep;
  } latStrobe_t;

endpackage

// File: rtl/lat_ctrl.sv
module lat_ctrl
  import lat_pkg::*;
#(
  parameter int QUAL_SHORT = 128,
  parameter int QUAL_LONG  = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  input  logic       oscTick,
  input  logic       tick256,
  input  logic       oscEnable,
  input  logic       autoMode,
  input  logic       runManual,
  input  logic       delaySel,
  output latStrobe_t strobe,
  output logic       lineLevel,
  output logic       linePrevLevel
);

  localparam int QMAX = (QUAL_LONG > QUAL_SHORT) ? QUAL_LONG : QUAL_SHORT;
  localparam int QW   = $clog2(QMAX) + 1;

  logic          syncA, syncB, prevB;
  logic [QW-1:0] qualCnt, qualLimit, qualNext;
  logic          qualDone, autoRun;
  logic          lineMoved, tickOk, qualHit;

  assign qualLimit = delaySel ? QW'(QUAL_LONG) : QW'(QUAL_SHORT);
  assign lineMoved = syncB ^ prevB;
  assign tickOk    = oscEnable & oscTick;
  assign qualNext  = qualCnt + QW'(1);
  assign qualHit   = tickOk & ~qualDone & ~lineMoved & (qualNext >= qualLimit);

  // two-stage synchroniser followed by edge-history flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  // level qualification: restarts on every change, saturates when done
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt  <= '0;
      qualDone <= 1'b0;
    end else if (lineMoved) begin
      qualCnt  <= '0;
      qualDone <= 1'b0;
    end else if (tickOk && !qualDone) begin
      qualCnt  <= qualNext;
      qualDone <= qualHit;
    end
  end

  // automatic run state follows the most recently qualified level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        autoRun <= 1'b0;
    else if (qualHit) autoRun <= prevB;
  end

  always_comb begin
    strobe.timerStep = oscEnable & tick256 & (autoMode ? autoRun : runManual);
    strobe.cycleStep = oscEnable & prevB & ~syncB & qualDone;
  end

  assign lineLevel     = syncB;
  assign linePrevLevel = prevB;

endmodule

// File: rtl/lat_counter.sv
module lat_counter #(
  parameter int BYTES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               step,
  output logic [8*BYTES-1:0] value
);

  logic [BYTES:0] carry;

  assign carry[0] = step;

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    logic [7:0] lane;

    assign carry[i+1] = carry[i] & (lane == 8'hFF);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         lane <= 8'h00;
      else if (carry[i]) lane <= lane + 8'h01;
    end

    assign value[8*i +: 8] = lane;
  end

endmodule

// File: rtl/lat_datapath.sv
module lat_datapath
  import lat_pkg::*;
#(
  parameter int TIMER_BYTES = 5,
  parameter int CYCLE_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  latStrobe_t               strobe,
  output logic [8*TIMER_BYTES-1:0] intervalCount,
  output logic [8*CYCLE_BYTES-1:0] cycleCount
);

  lat_counter #(.BYTES(TIMER_BYTES)) timerU (
    .clk   (clk),
    .rstN  (rstN),
    .step  (strobe.timerStep),
    .value (intervalCount)
  );

  lat_counter #(.BYTES(CYCLE_BYTES)) cycleU (
    .clk   (clk),
    .rstN  (rstN),
    .step  (strobe.cycleStep),
    .value (cycleCount)
  );

endmodule

// File: rtl/lat_activity_timer.sv
module lat_activity_timer
  import lat_pkg::*;
#(
  parameter int TIMER_BYTES = 5,
  parameter int CYCLE_BYTES = 4,
  parameter int QUAL_SHORT  = 128,
  parameter int QUAL_LONG   = 4096
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lineIn,
  input  logic                     oscTick,
  input  logic                     tick256,
  input  logic                     oscEnable,
  input  logic                     autoMode,
  input  logic                     runManual,
  input  logic                     delaySel,
  output logic [8*TIMER_BYTES-1:0] intervalCount,
  output logic [8*CYCLE_BYTES-1:0] cycleCount
);

  latStrobe_t strobe;
  logic       lineLevel;
  logic       linePrevLevel;

  lat_ctrl #(.QUAL_SHORT(QUAL_SHORT), .QUAL_LONG(QUAL_LONG)) ctrlU (
    .clk           (clk),
    .rstN          (rstN),
    .lineIn        (lineIn),
    .oscTick       (oscTick),
    .tick256       (tick256),
    .oscEnable     (oscEnable),
    .autoMode      (autoMode),
    .runManual     (runManual),
    .delaySel      (delaySel),
    .strobe        (strobe),
    .lineLevel     (lineLevel),
    .linePrevLevel (linePrevLevel)
  );

  lat_datapath #(.TIMER_BYTES(TIMER_BYTES), .CYCLE_BYTES(CYCLE_BYTES)) dataU (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .intervalCount (intervalCount),
    .cycleCount    (cycleCount)
  );

endmodule

// File: rtl/lat_activity_timer_chk.sv
module lat_activity_timer_chk #(
  parameter int TW = 40,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          tick256,
  input logic          oscEnable,
  input logic          autoMode,
  input logic          runManual,
  input logic          lineLevel,
  input logic          linePrevLevel,
  input logic [TW-1:0] intervalCount,
  input logic [CW-1:0] cycleCount
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (intervalCount == '0 && cycleCount == '0));

  // R2
  timer_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick256 |=> $stable(intervalCount));

  // R2
  timer_single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick256 |=> (intervalCount == $past(intervalCount) ||
                 intervalCount == $past(intervalCount) + TW'(1)));

  // R3
  manual_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!autoMode && !runManual) |=> $stable(intervalCount));

  // R8
  cycle_needs_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(linePrevLevel && !lineLevel) |=> $stable(cycleCount));

  // R9
  osc_off_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscEnable |=> ($stable(intervalCount) && $stable(cycleCount)));

endmodule

bind lat_activity_timer lat_activity_timer_chk #(
  .TW(8*TIMER_BYTES),
  .CW(8*CYCLE_BYTES)
) chkU (
  .clk           (clk),
  .rstN          (rstN),
  .tick256       (tick256),
  .oscEnable     (oscEnable),
  .autoMode      (autoMode),
  .runManual     (runManual),
  .lineLevel     (lineLevel),
  .linePrevLevel (linePrevLevel),
  .intervalCount (intervalCount),
  .cycleCount    (cycleCount)
);

// File: tb/lat_activity_timer_test.sv
`timescale 1ns/1ps
module lat_activity_timer_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineIn = 1'b0, oscTick = 1'b0, tick256 = 1'b0, oscEnable = 1'b0;
  logic autoMode = 1'b0, runManual = 1'b0, delaySel = 1'b0;
  logic [39:0] intervalCount;
  logic [31:0] cycleCount;
  logic [7:0]  smallInterval, smallCycle;

  int checks = 0, errors = 0;
  int oscDiv = 1, tickDiv = 4, cycN = 0;
  bit finished = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  lat_activity_timer uut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .oscTick(oscTick), .tick256(tick256),
    .oscEnable(oscEnable), .autoMode(autoMode), .runManual(runManual),
    .delaySel(delaySel), .intervalCount(intervalCount), .cycleCount(cycleCount)
  );

  lat_activity_timer #(.TIMER_BYTES(1), .CYCLE_BYTES(1)) uutSmall (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .oscTick(oscTick), .tick256(tick256),
    .oscEnable(oscEnable), .autoMode(autoMode), .runManual(runManual),
    .delaySel(delaySel), .intervalCount(smallInterval), .cycleCount(smallCycle)
  );

  // behavioural reference
  bit mS1, mS2, mPrev, mDone, mRun;
  int mQ;
  longint unsigned mInt, mCyc;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mPrev = 0; mDone = 0; mRun = 0; mQ = 0; mInt = 0; mCyc = 0;
    end else begin
      int lim;
      lim = delaySel ? 4096 : 128;
      if (oscEnable && mPrev && !mS2 && mDone) mCyc = mCyc + 1;
      if (oscEnable && tick256 && (autoMode ? mRun : runManual)) mInt = mInt + 1;
      if (mS2 != mPrev) begin
        mQ = 0; mDone = 0;
      end else if (oscEnable && oscTick && !mDone) begin
        mQ = mQ + 1;
        if (mQ >= lim) begin mDone = 1; mRun = mPrev; end
      end
      mPrev = mS2; mS2 = mS1; mS1 = lineIn;
    end
  end

  task automatic compare();
    longint unsigned eI, eC;
    eI = mInt & 64'hFF_FFFF_FFFF;
    eC = mCyc & 64'hFFFF_FFFF;
    checks++;
    if (intervalCount !== eI[39:0] || cycleCount !== eC[31:0]) begin
      errors++;
      $display("FAIL %s: interval %0h cycle %0h expected interval %0h cycle %0h",
               curReq, intervalCount, cycleCount, eI, eC);
    end
    checks++;
    if (smallInterval !== eI[7:0] || smallCycle !== eC[7:0]) begin
      errors++;
      $display("FAIL %s (R10 narrow): interval %0h cycle %0h expected %0h %0h",
               curReq, smallInterval, smallCycle, eI[7:0], eC[7:0]);
    end
  endtask

  // advance n cycles: compare at each falling edge, then drive tick enables
  task automatic hold(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      cycN++;
      oscTick = (cycN % oscDiv) == 0;
      tick256 = (cycN % tickDiv) == 0;
    end
  endtask

  task automatic lineCycle(int hi, int lo);
    lineIn = 1'b1; hold(hi);
    lineIn = 1'b0; hold(lo);
  endtask

  task automatic expectVal(string req, longint unsigned got, longint unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish();
  end

  initial begin
    longint unsigned snap;
    oscEnable = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    expectVal("R1 interval", intervalCount, 0);
    expectVal("R1 cycle", cycleCount, 0);
    rstN = 1'b1;
    hold(2);

    // R3: manual mode, line activity ignored
    curReq = "R3";
    runManual = 1'b1;
    lineCycle(200, 200);
    snap = intervalCount;
    expectVal("R2 timer advanced in manual run", (snap > 0) ? 1 : 0, 1);
    runManual = 1'b0;
    lineCycle(200, 200);
    expectVal("R3 timer held with run bit clear", intervalCount, snap);

    // R4/R5: automatic start and stop
    curReq = "R4";
    autoMode = 1'b1;
    lineIn = 1'b1; hold(140);
    curReq = "R5";
    lineIn = 1'b0; hold(140);
    snap = intervalCount;
    hold(40);
    expectVal("R5 timer stopped after qualified low", intervalCount, snap);

    // R7: glitches restart qualification
    curReq = "R7";
    for (int k = 0; k < 3; k++) begin
      lineIn = 1'b1; hold(100);
      lineIn = 1'b0; hold(4);
    end
    expectVal("R7 unqualified highs did not start timer", intervalCount, snap);
    lineIn = 1'b1; hold(120);
    lineIn = 1'b0; hold(3);
    lineIn = 1'b1; hold(140);
    lineIn = 1'b0; hold(60);

    // R8: qualified and unqualified falling edges
    curReq = "R8";
    snap = cycleCount;
    lineCycle(60, 140);
    expectVal("R8 fall after short high not counted", cycleCount, snap);
    lineCycle(135, 140);
    expectVal("R8 fall after qualified high counted", cycleCount, snap + 1);
    lineCycle(129, 10);
    lineCycle(131, 10);

    // R6: long qualification period
    curReq = "R6";
    delaySel = 1'b1;
    snap = cycleCount;
    lineCycle(2000, 200);
    expectVal("R6 fall after 2000-tick high not counted", cycleCount, snap);
    lineCycle(4105, 4105);
    expectVal("R6 fall after 4096-tick high counted", cycleCount, snap + 1);
    delaySel = 1'b0;

    // R9: oscillator stopped mid-qualification and while running
    curReq = "R9";
    lineIn = 1'b1; hold(60);
    oscEnable = 1'b0; hold(300);
    snap = intervalCount;
    oscEnable = 1'b1; hold(90);
    oscEnable = 1'b0;
    lineIn = 1'b0; hold(200);
    expectVal("R9 nothing advanced while stopped", intervalCount, mInt & 64'hFF_FFFF_FFFF);
    oscEnable = 1'b1; hold(150);

    // sparse oscillator ticks stretch qualification
    curReq = "R4";
    oscDiv = 3;
    lineCycle(300, 300);
    lineCycle(450, 450);
    oscDiv = 1;

    // R10: wrap of narrow counters, manual timer then many line cycles
    curReq = "R10";
    autoMode = 1'b0; runManual = 1'b1;
    hold(1200);
    runManual = 1'b0;
    for (int k = 0; k < 260; k++) lineCycle(135, 135);
    expectVal("R10 narrow cycle counter wrapped", smallCycle, mCyc & 64'hFF);

    finish();
  end

endmodule